// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration port of a clock generator. A two-wire serial bus master (I2C, standard mode, 100 kbit/s) writes and reads a bank of seven 8-bit configuration bytes through it. Each stored byte drives the generator in parallel. Byte 0 holds the function controls: bit 0 tristates every clock output and bit 1 enables spread spectrum. Bit 2 picks down spread over centre spread, and bit 3 picks the software frequency code over the strap pins. Bits 6:4 hold the software frequency code, and bit 7 picks the smaller spread amount (0.6 % rather than 1.5 %). Bytes 1 to 6 are per-output enable masks.

The block has no sub-address. A write starts with the device address in write form. Two filler bytes follow: they are acknowledged and then thrown away. Every byte after that lands in byte 0, then byte 1, and so on upward, until a STOP or a new START. A read starts with the device address in read form, and the slave then returns byte 0, byte 1, and onward for as long as the master acknowledges. Both bus lines are oversampled in the system clock domain. SDA is only ever pulled low or released. While the power-down input is high, the slave lets go of the bus and keeps its contents.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The slave acknowledges the address byte D2h (write) and D3h (read). For any other address byte it does not acknowledge, and it ignores the bus until the next START.
- R2: After a write address, the next two bytes are acknowledged, and their values change no stored byte.
- R3: Data bytes of a write are stored in ascending order from byte 0, with byte k on cfg_bytes[8k+7:8k]. A STOP after any complete byte leaves every byte written so far with its new value.
- R4: Write data bytes after byte 6 are acknowledged and change nothing.
- R5: After a read address, the slave sends byte 0, byte 1 and onward, MSB first. It sends FFh for any byte after byte 6, and stops driving after a byte that the master does not acknowledge.
- R6: After reset, byte 0 is 00h and bytes 1 to 6 are FFh.
- R7: While pwr_dn is high, SDA is released, no byte is acknowledged and every stored byte keeps its value.
- R8: A repeated START aborts the transfer in progress and restarts address reception, so the next write begins again at byte 0.
- R9: The slave changes its SDA drive only while SCL is low, and it releases SDA after a STOP and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down: release the bus, hold contents |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| cfg_bytes | output | 56 | Stored bytes, byte k at bits 8k+7:8k |

## Verification
A wrong internal state in this block reaches the ports within one bus byte. A bad address compare or a bad filler-byte count shows as a wrong acknowledge bit in the ninth SCL pulse. A bad write pointer shows on cfg_bytes a few system clocks after the falling SCL edge that ends the byte, as a byte stored in the wrong lane or a byte lost. A bad read pointer or a bad shift shows in the very next bit the master samples. The power-down and repeated-START paths are checked at the ports by acknowledge bits and by cfg_bytes holding its value.

// File: rtl/cfgi2c_pkg.sv
// Package: shared types for the serial configuration slave.
// Assumes: one protocol engine per instance; byte width fixed at 8 by the bus.
package cfgi2c_pkg;

    localparam int unsigned BYTE_W = 8;

    // Protocol engine states
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,   // waiting for START
        ST_RX     = 3'd1,   // shifting in a byte
        ST_RX_ACK = 3'd2,   // driving acknowledge for a received byte
        ST_TX     = 3'd3,   // shifting out a byte
        ST_TX_ACK = 3'd4    // sampling master acknowledge
    } slv_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
// Module: i2c_line_sync
// Brings SCL and SDA into the system clock domain through two flops each,
// then derives SCL edges and START/STOP conditions from the synced levels.
// Assumes: the system clock is at least ~8x the SCL rate, so each SCL phase
// spans several samples; idle bus level is high.
module i2c_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_meta, scl_sync, scl_prev;
    logic sda_meta, sda_sync, sda_prev;

    // Two-flop synchronizers plus one history flop per line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_meta <= 1'b1;
            scl_sync <= 1'b1;
            scl_prev <= 1'b1;
            sda_meta <= 1'b1;
            sda_sync <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_meta <= scl_in;
            scl_sync <= scl_meta;
            scl_prev <= scl_sync;
            sda_meta <= sda_in;
            sda_sync <= sda_meta;
            sda_prev <= sda_sync;
        end
    end

    // Edge and bus-condition decode from synced levels
    always_comb begin
        sda_lvl   = sda_sync;
        scl_rise  = scl_sync & ~scl_prev;
        scl_fall  = ~scl_sync & scl_prev;
        start_det = scl_sync & scl_prev & sda_prev & ~sda_sync;
        stop_det  = scl_sync & scl_prev & ~sda_prev & sda_sync;
    end

endmodule

// File: rtl/cfg_byte_bank.sv
// Module: cfg_byte_bank
// Holds the configuration bytes with per-byte reset defaults, one write port
// and one combinational read port; reads past the last byte return a fill value.
// Assumes: at most one write per cycle; write address already range-limited.
module cfg_byte_bank #(
    parameter int unsigned NUM_BYTES = 7,
    parameter int unsigned PTR_W     = 3,
    parameter logic [7:0]  BYTE0_DEF = 8'h00,
    parameter logic [7:0]  REST_DEF  = 8'hFF,
    parameter logic [7:0]  RD_FILL   = 8'hFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [PTR_W-1:0]       wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [PTR_W-1:0]       rd_addr,
    output logic [7:0]             rd_data,
    output logic [NUM_BYTES*8-1:0] bytes_flat
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(NUM_BYTES);

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        localparam logic [7:0] DEF = (g == 0) ? BYTE0_DEF : REST_DEF;
        logic [7:0] byte_q;

        // One storage byte, loaded when the write port addresses it
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                byte_q <= DEF;
            end else if (wr_en && (wr_addr == PTR_W'(g))) begin
                byte_q <= wr_data;
            end
        end

        assign bytes_flat[g*8 +: 8] = byte_q;

        // R6: every byte comes out of reset at its default
        p_reset_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> (byte_q == DEF));
    end

    // Read mux with fill value beyond the last byte
    always_comb begin
        rd_data = RD_FILL;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_addr == PTR_W'(i)) begin
                rd_data = bytes_flat[i*8 +: 8];
            end
        end
    end

    // R4: the write port never addresses a byte that does not exist
    p_wr_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr < LAST_IDX));

    // R3: stored bytes change only through a write
    p_hold_without_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bytes_flat));

endmodule

// File: rtl/i2c_cfg_fsm.sv
// Module: i2c_cfg_fsm
// Bus protocol engine: address match, filler-byte skip, sequential write
// pointer, sequential read with master acknowledge, open-drain SDA control.
// Assumes: edges and START/STOP come pre-decoded from i2c_line_sync; no
// clock stretching; SDA is only changed after a detected SCL fall.
module i2c_cfg_fsm
    import cfgi2c_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int unsigned NUM_BYTES   = 7,
    parameter int unsigned DUMMY_BYTES = 2,
    parameter int unsigned PTR_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_data,
    output logic             sda_low,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic [PTR_W-1:0] rd_addr
);

    localparam int unsigned  DCNT_W   = $clog2(DUMMY_BYTES + 1);
    localparam logic [DCNT_W-1:0] DUMMY_LAST = DCNT_W'(DUMMY_BYTES);
    localparam logic [DCNT_W-1:0] DONE_ONE   = DCNT_W'(1);
    localparam logic [PTR_W-1:0]  PTR_END    = PTR_W'(NUM_BYTES);
    localparam logic [PTR_W-1:0]  PTR_ONE    = PTR_W'(1);

    slv_state_e        state;
    logic [3:0]        bit_cnt;
    logic [7:0]        rx_shift;
    logic [7:0]        tx_shift;
    logic              is_addr;
    logic              rd_mode;
    logic              master_ack;
    logic [DCNT_W-1:0] dummy_cnt;
    logic [PTR_W-1:0]  ptr;

    assign rd_addr = ptr;

    // Protocol sequencing, byte shifting and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            rx_shift   <= '0;
            tx_shift   <= '0;
            is_addr    <= 1'b0;
            rd_mode    <= 1'b0;
            master_ack <= 1'b0;
            dummy_cnt  <= '0;
            ptr        <= '0;
            sda_low    <= 1'b0;
            wr_en      <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
        end else begin
            wr_en <= 1'b0;
            if (pwr_dn) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else if (start_det) begin
                state     <= ST_RX;
                bit_cnt   <= '0;
                is_addr   <= 1'b1;
                rd_mode   <= 1'b0;
                dummy_cnt <= '0;
                ptr       <= '0;
                sda_low   <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                sda_low <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && (bit_cnt < 4'd8)) begin
                            rx_shift <= {rx_shift[6:0], sda_lvl};
                            bit_cnt  <= bit_cnt + 4'd1;
                        end else if (scl_fall && (bit_cnt == 4'd8)) begin
                            if (is_addr) begin
                                if (rx_shift[7:1] == DEV_ADDR) begin
                                    sda_low <= 1'b1;
                                    rd_mode <= rx_shift[0];
                                    state   <= ST_RX_ACK;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else begin
                                sda_low <= 1'b1;
                                state   <= ST_RX_ACK;
                                if (dummy_cnt < DUMMY_LAST) begin
                                    dummy_cnt <= dummy_cnt + DONE_ONE;
                                end else if (ptr < PTR_END) begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= rx_shift;
                                    ptr     <= ptr + PTR_ONE;
                                end
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            is_addr <= 1'b0;
                            bit_cnt <= '0;
                            if (is_addr && rd_mode) begin
                                state    <= ST_TX;
                                tx_shift <= rd_data;
                                sda_low  <= ~rd_data[7];
                                if (ptr < PTR_END) ptr <= ptr + PTR_ONE;
                            end else begin
                                state   <= ST_RX;
                                sda_low <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_low <= 1'b0;
                                state   <= ST_TX_ACK;
                            end else begin
                                tx_shift <= {tx_shift[6:0], 1'b0};
                                sda_low  <= ~tx_shift[6];
                                bit_cnt  <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            master_ack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            if (master_ack) begin
                                state    <= ST_TX;
                                bit_cnt  <= '0;
                                tx_shift <= rd_data;
                                sda_low  <= ~rd_data[7];
                                if (ptr < PTR_END) ptr <= ptr + PTR_ONE;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: begin
                        sda_low <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R7: power-down releases the line and blocks writes on the next cycle
    p_pd_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!sda_low && !wr_en));

    // R9: STOP releases the line
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_low);

    // R9: drive changes only follow an SCL fall or a bus/power event
    p_drive_on_low_scl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low) |-> $past(scl_fall || start_det || stop_det || pwr_dn));

    // R1: an idle slave never pulls the line
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_low);

    // R8: any START restarts address reception at byte 0
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det && !pwr_dn) |=> (state == ST_RX && bit_cnt == 4'd0 && is_addr && ptr == '0));

    // R2: no write before both filler bytes have passed
    p_wr_after_filler_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dummy_cnt == DUMMY_LAST));

endmodule

// File: rtl/cfg_i2c_slave.sv
// Module: cfg_i2c_slave (top)
// Serial configuration slave for a clock generator: line synchronizer,
// protocol engine and byte bank; stored bytes are exported in parallel.
// Assumes: system clock much faster than SCL; SDA is open drain, so the
// only drive is sda_drive_low.
module cfg_i2c_slave #(
    parameter logic [6:0]  DEV_ADDR    = 7'h69,
    parameter int unsigned NUM_BYTES   = 7,
    parameter int unsigned DUMMY_BYTES = 2,
    parameter logic [7:0]  BYTE0_DEF   = 8'h00,
    parameter logic [7:0]  REST_DEF    = 8'hFF,
    parameter logic [7:0]  RD_FILL     = 8'hFF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pwr_dn,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_drive_low,
    output logic [NUM_BYTES*8-1:0] cfg_bytes
);

    localparam int unsigned PTR_W = $clog2(NUM_BYTES + 1);

    logic             sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr, rd_addr;
    logic [7:0]       wr_data, rd_data;

    i2c_line_sync i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_cfg_fsm #(
        .DEV_ADDR    (DEV_ADDR),
        .NUM_BYTES   (NUM_BYTES),
        .DUMMY_BYTES (DUMMY_BYTES),
        .PTR_W       (PTR_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_low   (sda_drive_low),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr)
    );

    cfg_byte_bank #(
        .NUM_BYTES (NUM_BYTES),
        .PTR_W     (PTR_W),
        .BYTE0_DEF (BYTE0_DEF),
        .REST_DEF  (REST_DEF),
        .RD_FILL   (RD_FILL)
    ) i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .bytes_flat (cfg_bytes)
    );

endmodule

// File: tb/test_cfg_i2c_slave.sv
// Bench: bus master model with an open-drain line, byte model of the bank,
// seeded random transfers plus directed corner cases.
module test_cfg_i2c_slave;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;       // system clocks per quarter SCL bit
    localparam int WD_CYCLES  = 190000;
    localparam logic [7:0] AW = 8'hD2;
    localparam logic [7:0] AR = 8'hD3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_low;
    logic [55:0] cfg;
    logic        sda_bus;
    logic [7:0]  model [7];
    int          n_chk = 0;
    int          n_fail = 0;

    assign sda_bus = m_sda & ~sda_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_i2c_slave i_cfg_i2c_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwr_dn        (pwr_dn),
        .scl_in        (m_scl),
        .sda_in        (sda_bus),
        .sda_drive_low (sda_low),
        .cfg_bytes     (cfg)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        b = sda_bus; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic put_byte(input logic [7:0] d, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        acked = !a;
    endtask

    task automatic get_byte(output logic [7:0] d, input bit give_ack);
        logic b;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            get_bit(b);
            d = {d[6:0], b};
        end
        put_bit(!give_ack);
    endtask

    function automatic logic [7:0] exp_read(input int idx);
        return (idx < 7) ? model[idx] : 8'hFF;
    endfunction

    task automatic check_regs(input string req);
        for (int i = 0; i < 7; i++)
            check(cfg[i*8 +: 8] == model[i], req, cfg[i*8 +: 8], model[i]);
    endtask

    // Full write transfer; the model is updated only when acks are expected
    task automatic wr_txn(input logic [7:0] ab, input int n, input bit exp_ack);
        bit acked;
        logic [7:0] d;
        bus_start();
        put_byte(ab, acked);
        check(acked == exp_ack, "R1 address ack", acked, exp_ack);
        for (int i = 0; i < 2; i++) begin
            put_byte(8'($urandom), acked);
            check(acked == exp_ack, "R2 filler ack", acked, exp_ack);
        end
        for (int i = 0; i < n; i++) begin
            d = 8'($urandom);
            put_byte(d, acked);
            if (i < 7) begin
                check(acked == exp_ack, "R3 data ack", acked, exp_ack);
                if (exp_ack) model[i] = d;
            end else begin
                check(acked == exp_ack, "R4 overflow ack", acked, exp_ack);
            end
        end
        bus_stop();
        qwait();
        check_regs("R2 R3 R4 stored bytes");
    endtask

    task automatic rd_txn(input int n);
        bit acked;
        logic [7:0] d;
        bus_start();
        put_byte(AR, acked);
        check(acked, "R1 read address ack", acked, 1);
        for (int i = 0; i < n; i++) begin
            get_byte(d, i < n - 1);
            check(d == exp_read(i), "R5 read data", d, exp_read(i));
        end
        qwait();
        check(sda_low == 1'b0, "R5 released after nack", sda_low, 0);
        bus_stop();
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", WD_CYCLES, WD_CYCLES);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        bit acked;
        logic [7:0] d;
        logic [7:0] bad;
        void'($urandom(32'd20240611));
        model[0] = 8'h00;
        for (int i = 1; i < 7; i++) model[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R6: reset state
        check_regs("R6 reset default");
        check(sda_low == 1'b0, "R9 idle release", sda_low, 0);

        // R5: read defaults, including overflow fill
        rd_txn(9);

        // R3: write byte 0 field layout then stop early
        wr_txn(AW, 1, 1'b1);
        // R2: filler only, nothing changes
        wr_txn(AW, 0, 1'b1);
        // R4: write past the end
        wr_txn(AW, 9, 1'b1);
        rd_txn(9);

        // R1: wrong addresses ignored
        for (int k = 0; k < 3; k++) begin
            bad = {7'h69 ^ 7'(($urandom % 127) + 1), 1'(k)};
            wr_txn(bad, 3, 1'b0);
        end

        // R7: power-down
        pwr_dn = 1'b1;
        wr_txn(AW, 4, 1'b0);
        check(sda_low == 1'b0, "R7 released in power-down", sda_low, 0);
        pwr_dn = 1'b0;
        qwait();
        check_regs("R7 contents kept");

        // R8: repeated START mid-filler, then mid-data, then into a read
        bus_start();
        put_byte(AW, acked);
        put_byte(8'h11, acked);
        bus_start();
        put_byte(AW, acked);
        check(acked, "R8 ack after restart", acked, 1);
        put_byte(8'h22, acked);
        put_byte(8'h33, acked);
        put_byte(8'h5A, acked);
        model[0] = 8'h5A;
        bus_start();
        put_byte(AW, acked);
        put_byte(8'h00, acked);
        put_byte(8'h00, acked);
        put_byte(8'hC3, acked);
        model[0] = 8'hC3;
        bus_start();
        put_byte(AR, acked);
        check(acked, "R8 read after restart", acked, 1);
        get_byte(d, 1'b1);
        check(d == model[0], "R8 restart read byte 0", d, model[0]);
        get_byte(d, 1'b0);
        check(d == model[1], "R8 restart read byte 1", d, model[1]);
        bus_stop();
        qwait();
        check_regs("R8 restart stored");

        // Random mix
        for (int k = 0; k < 24; k++) begin
            if (($urandom % 3) == 0) rd_txn(1 + int'($urandom % 9));
            else wr_txn(AW, int'($urandom % 10), 1'b1);
        end

        check(sda_low == 1'b0, "R9 idle release at end", sda_low, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule